// File: doc/BRIEF.md
# Integer ALU with Width-Aware Status Flags

This block performs one integer operation per enabled clock edge on two 64-bit operands and keeps a five-bit status register next to the result. A size select chooses 8, 16, 32 or 64 bits. Both the arithmetic and the flags are evaluated at that width only. The first operand also acts as the destination in the accumulator sense: a narrow write replaces only the low bits of operand A and passes its upper bits through to the registered result.

Each opcode owns a fixed subset of the flags and leaves every other flag untouched. This allows a carry chain to pass through increment and decrement, and lets carry be forced without disturbing the condition codes. Flag register bit order, from bit 4 down to bit 0, is {overflow, sign, zero, parity, carry}. Size codes are 0=8, 1=16, 2=32 and 3=64 bits. The operands are assumed stable around the clock edge, and the reset is assumed to be already synchronized to the clock on release.

Top module: `flagged_alu`

## Requirements
- R1: While reset is low, dest_o reads 0 and flags_o reads 0 (bit 4..0 = {OF,SF,ZF,PF,CF}).
- R2: With en_i low, or with an opcode from 11 to 15, neither dest_o nor flags_o changes on the clock edge.
- R3: ADD (code 0) and SUB (code 2) update all five flags. Carry is the carry out of the selected width for ADD and the unsigned borrow (A < B) for SUB. Overflow is set when signed arithmetic at that width wraps.
- R4: ADC (code 1) adds the current carry flag (flags_o bit 0) into the least significant bit.
- R5: INC (code 3) and DEC (code 4) add or subtract 1 and update OF, SF, ZF and PF. They leave CF (bit 0) unchanged. For example, INC of 0x7F at 8 bits gives 0x80 with OF (bit 4) set.
- R6: ZF (bit 2) is set only when the result bits within the selected width are all zero, whatever the bits above that width hold.
- R7: SF (bit 3) equals the top bit of the result at the selected width (bit 7, 15, 31 or 63).
- R8: PF (bit 1) is set when the low 8 result bits hold an even number of ones.
- R9: AND (5), OR (6), XOR (7) and TEST (8) clear CF and OF and set ZF, SF and PF from the bitwise result.
- R10: TEST (code 8) updates flags from A AND B but leaves dest_o unchanged.
- R11: STC (code 9) forces CF to 1 and CLC (code 10) forces CF to 0. Flag bits 4..1 and dest_o stay unchanged.
- R12: For codes 0 to 7 at a width below 64, dest_o takes the bits above the width from opa_i and the low bits from the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Enables the register update on this edge |
| op_i | input | 4 | Operation code (0..10 defined) |
| size_i | input | 2 | Operand width: 0=8, 1=16, 2=32, 3=64 bits |
| opa_i | input | 64 | Operand A and destination source |
| opb_i | input | 64 | Operand B |
| dest_o | output | 64 | Registered destination value |
| flags_o | output | 5 | Registered flags {OF,SF,ZF,PF,CF} |

## Verification
The bench aims at the width boundaries.

- An 8-bit add whose upper operand bits are non-zero must still raise ZF. A design that reduces all 64 bits would leave ZF clear.
- 0x7F+1 must raise OF. 0x80..0-1 at 64 bits must also raise OF. A design that tests the wrong sign bit would miss one of these.
- Carry is placed before INC and DEC, before ADC, and before the logic operations. A design that does not mask CF would clobber a carry that should survive, and one that ignores the carry-in would add the wrong value.
- TEST, STC, CLC, the unused codes and cycles with the enable low must each leave the destination as it was. A pseudo-random sweep across all opcodes and widths then compares every result against an independent model.

// File: rtl/falu_pkg.sv
package falu_pkg;

  localparam int FLAG_W = 5;
  localparam int FL_CF  = 0;
  localparam int FL_PF  = 1;
  localparam int FL_ZF  = 2;
  localparam int FL_SF  = 3;
  localparam int FL_OF  = 4;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_ADC  = 4'd1,
    OP_SUB  = 4'd2,
    OP_INC  = 4'd3,
    OP_DEC  = 4'd4,
    OP_AND  = 4'd5,
    OP_OR   = 4'd6,
    OP_XOR  = 4'd7,
    OP_TEST = 4'd8,
    OP_STC  = 4'd9,
    OP_CLC  = 4'd10
  } falu_op_e;

  // Opcodes that replace the destination bits.
  function automatic logic op_writes(input logic [3:0] op);
    return (op <= OP_XOR);
  endfunction

  // Bitwise class: results come from the logic unit.
  function automatic logic op_is_logic(input logic [3:0] op);
    return (op == OP_AND) || (op == OP_OR) || (op == OP_XOR) || (op == OP_TEST);
  endfunction

  // Per-opcode set of flags that may change.
  function automatic logic [FLAG_W-1:0] op_flag_mask(input logic [3:0] op);
    logic [FLAG_W-1:0] m;
    m = '0;
    case (op)
      OP_ADD, OP_ADC, OP_SUB,
      OP_AND, OP_OR, OP_XOR, OP_TEST: m = '1;
      OP_INC, OP_DEC:                 m = 5'b11110;
      OP_STC, OP_CLC:                 m = 5'b00001;
      default:                        m = '0;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/falu_arith.sv
module falu_arith
  import falu_pkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter int NUM_SIZES = 4,
  localparam int DATA_W   = BYTE_W << (NUM_SIZES - 1),
  localparam int SIZE_W   = $clog2(NUM_SIZES)
) (
  input  logic [3:0]        op_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              cf_i,
  output logic [DATA_W-1:0] res_o,
  output logic              carry_o,
  output logic              ovf_o
);

  logic              sub_mode;
  logic              unit_step;
  logic              cin;
  logic [DATA_W-1:0] b_sel;
  logic [DATA_W-1:0] b_eff;

  logic [DATA_W-1:0] res_w   [NUM_SIZES];
  logic              cout_w  [NUM_SIZES];
  logic              ovf_w   [NUM_SIZES];

  always_comb begin
    sub_mode  = (op_i == OP_SUB) || (op_i == OP_DEC);
    unit_step = (op_i == OP_INC) || (op_i == OP_DEC);
    b_sel     = unit_step ? DATA_W'(1) : b_i;
    b_eff     = sub_mode ? ~b_sel : b_sel;
    if (sub_mode)
      cin = 1'b1;
    else if (op_i == OP_ADC)
      cin = cf_i;
    else
      cin = 1'b0;
  end

  // One adder slice per supported width; the size select picks one.
  for (genvar i = 0; i < NUM_SIZES; i++) begin : g_width
    localparam int W = BYTE_W << i;
    logic [W:0] sum;
    assign sum      = {1'b0, a_i[W-1:0]} + {1'b0, b_eff[W-1:0]} + {{W{1'b0}}, cin};
    assign res_w[i] = DATA_W'(sum[W-1:0]);
    // Subtraction reports a borrow, the inverse of the carry out.
    assign cout_w[i] = sum[W] ^ sub_mode;
    assign ovf_w[i]  = (a_i[W-1] == b_eff[W-1]) && (sum[W-1] != a_i[W-1]);
  end

  assign res_o   = res_w[size_i];
  assign carry_o = cout_w[size_i];
  assign ovf_o   = ovf_w[size_i];

endmodule

// File: rtl/falu_logic.sv
module falu_logic
  import falu_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic [3:0]        op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] res_o
);

  always_comb begin
    case (op_i)
      OP_OR:   res_o = a_i | b_i;
      OP_XOR:  res_o = a_i ^ b_i;
      default: res_o = a_i & b_i;   // AND and TEST
    endcase
  end

endmodule

// File: rtl/falu_flags.sv
module falu_flags
  import falu_pkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter int NUM_SIZES = 4,
  localparam int DATA_W   = BYTE_W << (NUM_SIZES - 1),
  localparam int SIZE_W   = $clog2(NUM_SIZES)
) (
  input  logic [3:0]        op_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic [DATA_W-1:0] res_i,    // already zero above the width
  input  logic              carry_i,
  input  logic              ovf_i,
  input  logic [FLAG_W-1:0] flags_q_i,
  output logic [FLAG_W-1:0] flags_d_o
);

  logic              sign_w [NUM_SIZES];
  logic [FLAG_W-1:0] cand;
  logic [FLAG_W-1:0] upd;
  logic              is_log;

  for (genvar i = 0; i < NUM_SIZES; i++) begin : g_sign
    assign sign_w[i] = res_i[(BYTE_W << i) - 1];
  end

  always_comb begin
    is_log = op_is_logic(op_i);
    upd    = op_flag_mask(op_i);

    cand[FL_ZF] = ~|res_i;
    cand[FL_SF] = sign_w[size_i];
    cand[FL_PF] = ~^res_i[BYTE_W-1:0];
    cand[FL_OF] = is_log ? 1'b0 : ovf_i;
    if (is_log || op_i == OP_CLC)
      cand[FL_CF] = 1'b0;
    else if (op_i == OP_STC)
      cand[FL_CF] = 1'b1;
    else
      cand[FL_CF] = carry_i;

    flags_d_o = (cand & upd) | (flags_q_i & ~upd);
  end

endmodule

// File: rtl/flagged_alu.sv
module flagged_alu
  import falu_pkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter int NUM_SIZES = 4,
  localparam int DATA_W   = BYTE_W << (NUM_SIZES - 1),
  localparam int SIZE_W   = $clog2(NUM_SIZES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [3:0]        op_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic [DATA_W-1:0] opa_i,
  input  logic [DATA_W-1:0] opb_i,
  output logic [DATA_W-1:0] dest_o,
  output logic [FLAG_W-1:0] flags_o
);

  logic [DATA_W-1:0] dest_q,  dest_d;
  logic [FLAG_W-1:0] flags_q, flags_d;
  logic [DATA_W-1:0] ar_res,  lg_res, low_res, wmask;
  logic              ar_carry, ar_ovf;
  logic [DATA_W-1:0] wmask_w [NUM_SIZES];

  for (genvar i = 0; i < NUM_SIZES; i++) begin : g_mask
    localparam int W = BYTE_W << i;
    if (W == DATA_W) begin : g_full
      assign wmask_w[i] = '1;
    end else begin : g_part
      assign wmask_w[i] = {{(DATA_W-W){1'b0}}, {W{1'b1}}};
    end
  end

  falu_arith #(.BYTE_W(BYTE_W), .NUM_SIZES(NUM_SIZES)) u_arith (
    .op_i    (op_i),
    .size_i  (size_i),
    .a_i     (opa_i),
    .b_i     (opb_i),
    .cf_i    (flags_q[FL_CF]),
    .res_o   (ar_res),
    .carry_o (ar_carry),
    .ovf_o   (ar_ovf)
  );

  falu_logic #(.DATA_W(DATA_W)) u_logic (
    .op_i  (op_i),
    .a_i   (opa_i),
    .b_i   (opb_i),
    .res_o (lg_res)
  );

  falu_flags #(.BYTE_W(BYTE_W), .NUM_SIZES(NUM_SIZES)) u_flags (
    .op_i      (op_i),
    .size_i    (size_i),
    .res_i     (low_res),
    .carry_i   (ar_carry),
    .ovf_i     (ar_ovf),
    .flags_q_i (flags_q),
    .flags_d_o (flags_d)
  );

  // Next-state: merge the width-limited result into operand A.
  always_comb begin
    wmask   = wmask_w[size_i];
    low_res = op_is_logic(op_i) ? (lg_res & wmask) : ar_res;
    dest_d  = dest_q;
    if (op_writes(op_i))
      dest_d = (opa_i & ~wmask) | low_res;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dest_q  <= '0;
      flags_q <= '0;
    end else if (en_i) begin
      dest_q  <= dest_d;
      flags_q <= flags_d;
    end
  end

  assign dest_o  = dest_q;
  assign flags_o = flags_q;

endmodule

// File: rtl/falu_checker.sv
module falu_checker
  import falu_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic        en_i,
  input logic [3:0]  op_i,
  input logic [1:0]  size_i,
  input logic [63:0] opa_i,
  input logic [63:0] dest_o,
  input logic [4:0]  flags_o
);

  a_r1_reset_clear: assert property (@(posedge clk_i)
    !rst_ni |=> (dest_o == '0) && (flags_o == '0));

  a_r2_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i || op_i > 4'd10) |=> $stable(dest_o) && $stable(flags_o));

  a_r5_step_keeps_carry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && (op_i == OP_INC || op_i == OP_DEC)) |=> flags_o[FL_CF] == $past(flags_o[FL_CF]));

  a_r6_zero_at_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && op_i == OP_ADD && size_i == 2'd1) |=> flags_o[FL_ZF] == (dest_o[15:0] == 16'h0));

  a_r7_sign_at_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && op_i == OP_ADD && size_i == 2'd1) |=> flags_o[FL_SF] == dest_o[15]);

  a_r8_parity_low_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && op_i == OP_OR) |=> flags_o[FL_PF] == ~^dest_o[7:0]);

  a_r9_logic_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && (op_i == OP_AND || op_i == OP_OR || op_i == OP_XOR || op_i == OP_TEST))
    |=> !flags_o[FL_CF] && !flags_o[FL_OF]);

  a_r10_test_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && op_i == OP_TEST) |=> $stable(dest_o));

  a_r11_stc_only_carry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && op_i == OP_STC) |=> flags_o[FL_CF] && (flags_o[4:1] == $past(flags_o[4:1])) && $stable(dest_o));

  a_r11_clc_only_carry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && op_i == OP_CLC) |=> !flags_o[FL_CF] && (flags_o[4:1] == $past(flags_o[4:1])) && $stable(dest_o));

  a_r12_upper_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && op_i <= OP_XOR && size_i == 2'd0) |=> dest_o[63:8] == $past(opa_i[63:8]));

endmodule

bind flagged_alu falu_checker u_falu_checker (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .en_i    (en_i),
  .op_i    (op_i),
  .size_i  (size_i),
  .opa_i   (opa_i),
  .dest_o  (dest_o),
  .flags_o (flags_o)
);

// File: tb/flagged_alu_tb_top.sv
`timescale 1ns/1ps
module flagged_alu_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        en;
  logic [3:0]  op;
  logic [1:0]  size;
  logic [63:0] opa, opb;
  logic [63:0] dest;
  logic [4:0]  flags;

  int checks   = 0;
  int failures = 0;
  bit finished = 0;

  typedef struct {
    logic [63:0] d;
    logic [4:0]  f;
    string       tag;
  } exp_t;
  exp_t sb_q[$];

  logic [63:0] m_dest  = '0;
  logic [4:0]  m_flags = '0;
  logic [63:0] rng     = 64'h9E37_79B9_7F4A_7C15;

  always #10 clk = ~clk;   // 50 MHz

  flagged_alu dut_i (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .en_i    (en),
    .op_i    (op),
    .size_i  (size),
    .opa_i   (opa),
    .opb_i   (opb),
    .dest_o  (dest),
    .flags_o (flags)
  );

  task automatic check(input string tag, input string what, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s %s got=%h exp=%h", tag, what, got, exp);
    end
  endtask

  // Reference model built from the requirements.
  task automatic model(input logic [3:0] o, input logic [1:0] s, input logic [63:0] a, input logic [63:0] b);
    int          w;
    logic [63:0] m, am, bm, bb, r;
    logic [64:0] sum;
    logic        c, v;
    logic [4:0]  f;
    w  = 8 << s;
    m  = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
    am = a & m;
    bm = b & m;
    r  = '0;
    c  = 1'b0;
    v  = 1'b0;
    f  = m_flags;
    case (o)
      4'd0, 4'd1, 4'd3: begin
        bb  = (o == 4'd3) ? 64'd1 : bm;
        sum = {1'b0, am} + {1'b0, bb} + {64'd0, (o == 4'd1) ? m_flags[0] : 1'b0};
        r   = sum[63:0] & m;
        c   = sum[w];
        v   = (am[w-1] == bb[w-1]) && (r[w-1] != am[w-1]);
      end
      4'd2, 4'd4: begin
        bb = (o == 4'd4) ? 64'd1 : bm;
        r  = (am - bb) & m;
        c  = am < bb;
        v  = (am[w-1] != bb[w-1]) && (r[w-1] != am[w-1]);
      end
      4'd5, 4'd8: r = am & bm;
      4'd6:       r = am | bm;
      4'd7:       r = am ^ bm;
      default:    r = '0;
    endcase
    if (o <= 4'd8) begin
      f[4] = v;
      f[3] = r[w-1];
      f[2] = (r == 64'd0);
      f[1] = ~^r[7:0];
      if (o != 4'd3 && o != 4'd4) f[0] = c;
    end else if (o == 4'd9) f[0] = 1'b1;
    else if (o == 4'd10) f[0] = 1'b0;
    if (o <= 4'd7) m_dest = (a & ~m) | r;
    m_flags = f;
  endtask

  // Driver: apply one operation and queue its expected outcome.
  task automatic drive(input logic e, input logic [3:0] o, input logic [1:0] s,
                       input logic [63:0] a, input logic [63:0] b, input string tag);
    exp_t it;
    @(negedge clk);
    en = e; op = o; size = s; opa = a; opb = b;
    if (e) model(o, s, a, b);
    it.d = m_dest; it.f = m_flags; it.tag = tag;
    sb_q.push_back(it);
  endtask

  // Monitor: compare after each edge, away from it.
  initial begin
    forever begin
      exp_t it;
      @(posedge clk);
      #5;
      if (sb_q.size() > 0) begin
        it = sb_q.pop_front();
        check(it.tag, "dest",  dest,         it.d);
        check(it.tag, "flags", {59'd0, flags}, {59'd0, it.f});
      end
    end
  end

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(20ns * 100000);
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; en = 1'b0; op = '0; size = '0; opa = '0; opb = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", "reset dest",  dest,           64'd0);
    check("R1", "reset flags", {59'd0, flags}, 64'd0);
    rst_n = 1'b1;

    // R3 R6 R12: 8-bit wrap to zero with non-zero upper bits
    drive(1, 4'd0, 2'd0, 64'h1122_3344_5566_77FF, 64'h01, "R3_R6_R12");
    // R5: 0x7F + 1 overflows, carry from before kept
    drive(1, 4'd3, 2'd0, 64'hAAAA_0000_0000_007F, 64'h0, "R5");
    // R4: add with carry at 16 bits
    drive(1, 4'd1, 2'd1, 64'h0001, 64'h0001, "R4");
    drive(1, 4'd10, 2'd0, 64'hFFFF, 64'hFFFF, "R11");
    drive(1, 4'd1, 2'd1, 64'h0001, 64'h0001, "R4");
    drive(1, 4'd9, 2'd3, 64'h1234, 64'h1, "R11");
    // R5: decrement wraps, carry stays set
    drive(1, 4'd4, 2'd0, 64'h00, 64'h0, "R5");
    // R3: borrow at 32 bits, upper preserved (R12)
    drive(1, 4'd2, 2'd2, 64'hDEAD_BEEF_0000_0000, 64'h1, "R3_R12");
    // R3 R7: signed overflow at 64 bits
    drive(1, 4'd2, 2'd3, 64'h8000_0000_0000_0000, 64'h1, "R3_R7");
    // R6: only bits in the width decide zero
    drive(1, 4'd0, 2'd0, 64'hFF00_0000_0000_0F00, 64'h0, "R6");
    drive(1, 4'd0, 2'd1, 64'h0000_0000_0000_00FF, 64'h01, "R6_R8");
    // R7: sign at 16 bits
    drive(1, 4'd0, 2'd1, 64'h7FFF, 64'h0001, "R7");
    // R8: parity of low byte
    drive(1, 4'd6, 2'd0, 64'h03, 64'h0, "R8");
    drive(1, 4'd6, 2'd0, 64'h07, 64'h0, "R8");
    // R9: logic ops clear carry and overflow
    drive(1, 4'd9, 2'd0, 64'h0, 64'h0, "R11");
    drive(1, 4'd5, 2'd2, 64'hF0F0_F0F0_8000_00F0, 64'hFFFF_FFFF_FFFF_FFFF, "R9");
    drive(1, 4'd9, 2'd0, 64'h0, 64'h0, "R11");
    drive(1, 4'd7, 2'd3, 64'h5555, 64'h5555, "R9");
    // R10: TEST touches flags only
    drive(1, 4'd8, 2'd3, 64'h8000_0000_0000_0000, 64'hFFFF_0000_0000_0000, "R10");
    // R2: disabled cycle and unused opcode
    drive(0, 4'd0, 2'd3, 64'h1, 64'h1, "R2");
    drive(1, 4'd13, 2'd0, 64'h55, 64'hAA, "R2");

    // Sweep across all opcodes and widths
    for (int k = 0; k < 80; k++) begin
      logic [63:0] a, b;
      rng = rng ^ (rng << 13); rng = rng ^ (rng >> 7); rng = rng ^ (rng << 17);
      a = rng;
      rng = rng ^ (rng << 13); rng = rng ^ (rng >> 7); rng = rng ^ (rng << 17);
      b = rng;
      drive(1, 4'(rng[35:32] % 4'd11), rng[41:40], a, b, "R3_R4_R5_sweep");
    end

    @(negedge clk);
    en = 1'b0;
    repeat (4) @(posedge clk);
    finish_run();
  end

endmodule